// File: doc/BRIEF.md
# Wide Register Dword Access Bridge

This bridge connects a 32-bit host register port to a bank of wide registers. The host side sees dword addresses. Behind them sit 128-bit control/status registers, each spanning four dwords, and 64-bit memory words, each spanning two. No wide value can move in one host transfer, so the bridge buffers in both directions.

For reads, it snapshots an entire wide value when a read sequence begins, then serves the remaining dwords from that snapshot. A register that clears when read therefore loses its contents exactly once per snapshot. For writes, it gathers dwords in a shared collection buffer and presents the whole value to the bank in a single commit cycle, once every dword has arrived.

A write to another target abandons a partly gathered value. Software must therefore serialise its wide writes. Registers selected by a parameter map skip collection and commit each dword as it is written.

Top module: `wide_access_bridge`

## Requirements
- R1: Host dword address `h_addr` (AW bits) has a region bit at AW-1. When it is 0, the target is a 128-bit register with index `h_addr[AW-2:2]` and dword lane `h_addr[1:0]`; lane k maps to bits 32k+31:32k. Wide-side addresses are the dword address of lane 0 of the target.
- R2: A host read of lane 0 always pulses `w_rd_en` in the same cycle and latches the full wide value. The chosen dword appears on `h_rdata` with `h_rvalid` high one cycle after the read strobe.
- R3: A host read of any lane of a target other than the one currently snapshotted, or with no snapshot held, also latches that target.
- R4: Reads of higher lanes of the snapshotted target return snapshot data, even if the live register has changed since.
- R5: Host writes to a 128-bit register produce no wide-side write until all four lanes have arrived. They then produce exactly one `w_wr_en` pulse, with `w_wr_strb`=4'b1111 and all four collected dwords.
- R6: When the region bit is 1, the target is a 64-bit memory word with index `h_addr[AW-2:1]` and lane `h_addr[0]`. Reads snapshot it the same way. Writes commit after both lanes arrive, with `w_wr_strb`=4'b0011.
- R7: Lanes may be written in any order. The commit happens on the write that completes the set.
- R8: A write to a different target while a collection is pending discards the pending dwords and starts a new collection.
- R9: After a commit the collection is empty, so a further partial write sequence to the same target does not commit.
- R10: `w_rd_en` is high only in cycles where a host read starts a new snapshot, so a clear-on-read side effect fires once per snapshot.
- R11: A 128-bit register whose bit is set in `BYPASS_MAP` commits each host write at once, with a one-hot `w_wr_strb` for its lane. Other lanes are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | AW | Host dword address |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data |
| h_rvalid | output | 1 | Read data valid, one cycle after `h_rd` |
| w_rd_en | output | 1 | Wide read (snapshot) pulse |
| w_rd_addr | output | AW | Wide read target, lane-0 dword address |
| w_rd_data | input | 128 | Wide read data, combinational from bank |
| w_wr_en | output | 1 | Wide commit pulse |
| w_wr_addr | output | AW | Wide commit target, lane-0 dword address |
| w_wr_strb | output | 4 | Per-lane commit strobes |
| w_wr_data | output | 128 | Wide commit data |

## Verification
Wide-side strobes are combinational with the host strobe. The bench counts `w_rd_en` and `w_wr_en` pulses at each rising edge. It reads the bank model at the falling edge after the commit edge. Read data is due one edge after the read strobe, so each read task raises `h_rd` at a falling edge and samples `h_rdata` at the next falling edge. The snapshot and drop cases poke the bank model between accesses. This proves that returned data comes from the snapshot and that discarded dwords never reach the bank.

// File: rtl/wide_access_bridge.sv
module wide_access_bridge #(
  parameter int AW = 8,
  parameter logic [2**(AW-3)-1:0] BYPASS_MAP = 'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] h_addr,
  input  logic          h_rd,
  input  logic          h_wr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  output logic          h_rvalid,
  output logic          w_rd_en,
  output logic [AW-1:0] w_rd_addr,
  input  logic [127:0]  w_rd_data,
  output logic          w_wr_en,
  output logic [AW-1:0] w_wr_addr,
  output logic [3:0]    w_wr_strb,
  output logic [127:0]  w_wr_data
);
  localparam int LANES = 4;

  wire          is_mem = h_addr[AW-1];
  wire [1:0]    dw     = is_mem ? {1'b0, h_addr[0]} : h_addr[1:0];
  wire [AW-1:0] base   = is_mem ? {h_addr[AW-1:1], 1'b0} : {h_addr[AW-1:2], 2'b00};
  wire [3:0]    need   = is_mem ? 4'b0011 : 4'b1111;
  wire [3:0]    lane   = 4'b0001 << dw;
  wire          byp    = !is_mem && BYPASS_MAP[h_addr[AW-2:2]];

  logic          rb_ok;
  logic [AW-1:0] rb_base;
  logic [127:0]  rb;

  assign w_rd_addr = base;
  assign w_rd_en   = h_rd && (dw == 2'd0 || !rb_ok || rb_base != base);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_ok    <= 1'b0;
      rb_base  <= '0;
      rb       <= '0;
      h_rdata  <= '0;
      h_rvalid <= 1'b0;
    end else begin
      h_rvalid <= h_rd;
      if (w_rd_en) begin
        rb      <= w_rd_data;
        rb_base <= base;
        rb_ok   <= 1'b1;
        h_rdata <= w_rd_data[dw*32 +: 32];
      end else if (h_rd) begin
        h_rdata <= rb[dw*32 +: 32];
      end
    end
  end

  logic [3:0]    wm;
  logic [AW-1:0] wb_base;
  logic [127:0]  wb;

  wire       fresh = (wm == 4'b0) || (wb_base != base);
  wire [3:0] wm_nx = (fresh ? 4'b0 : wm) | lane;

  for (genvar k = 0; k < LANES; k++) begin : g_merge
    assign w_wr_data[k*32 +: 32] = lane[k] ? h_wdata : wb[k*32 +: 32];
  end

  assign w_wr_en   = h_wr && (byp || wm_nx == need);
  assign w_wr_strb = byp ? lane : need;
  assign w_wr_addr = base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wm      <= '0;
      wb_base <= '0;
      wb      <= '0;
    end else if (h_wr && !byp) begin
      if (w_wr_en) begin
        wm <= '0;
      end else begin
        wm      <= wm_nx;
        wb_base <= base;
        for (int k = 0; k < LANES; k++)
          if (lane[k]) wb[k*32 +: 32] <= h_wdata;
      end
    end
  end
endmodule

module wide_access_bridge_chk #(parameter int AW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] h_addr,
  input logic          h_rd,
  input logic          h_wr,
  input logic          h_rvalid,
  input logic          w_rd_en,
  input logic          w_wr_en,
  input logic [3:0]    w_wr_strb,
  input logic [3:0]    wm
);
  assert_lane0_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && !h_addr[AW-1] && h_addr[1:0] == 2'd0) |-> w_rd_en);
  assert_rvalid_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd |=> h_rvalid);
  assert_no_spurious_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd |=> !h_rvalid);
  assert_latch_only_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    w_rd_en |-> h_rd);
  assert_commit_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    w_wr_en |-> h_wr);
  assert_mem_strb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_wr_en && h_addr[AW-1]) |-> w_wr_strb == 4'b0011);
  assert_csr_strb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (w_wr_en && !h_addr[AW-1]) |-> (w_wr_strb == 4'b1111 || $countones(w_wr_strb) == 1));
  assert_mask_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_wr_en && $countones(w_wr_strb) > 1) |=> wm == 4'b0);
endmodule

bind wide_access_bridge wide_access_bridge_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
  .h_rvalid(h_rvalid), .w_rd_en(w_rd_en), .w_wr_en(w_wr_en),
  .w_wr_strb(w_wr_strb), .wm(wm));

// File: tb/wide_access_bridge_tb_top.sv
module wide_access_bridge_tb_top;
  localparam int AW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic h_rd = 1'b0, h_wr = 1'b0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic h_rvalid, w_rd_en, w_wr_en;
  logic [AW-1:0] w_rd_addr, w_wr_addr;
  logic [127:0] w_rd_data, w_wr_data;
  logic [3:0] w_wr_strb;

  int total = 0, bad = 0;
  int n_commit = 0, n_latch = 0;
  logic [127:0] csr [32];
  logic [63:0]  mem [64];

  always #2 clk = ~clk;

  wide_access_bridge #(.AW(AW), .BYPASS_MAP(32'h80)) dut_i (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
    .w_rd_en(w_rd_en), .w_rd_addr(w_rd_addr), .w_rd_data(w_rd_data),
    .w_wr_en(w_wr_en), .w_wr_addr(w_wr_addr), .w_wr_strb(w_wr_strb),
    .w_wr_data(w_wr_data));

  assign w_rd_data = w_rd_addr[AW-1] ? {64'b0, mem[w_rd_addr[6:1]]} : csr[w_rd_addr[6:2]];

  always @(posedge clk) begin
    if (rst_n && w_wr_en) begin
      n_commit <= n_commit + 1;
      for (int k = 0; k < 4; k++)
        if (w_wr_strb[k]) begin
          if (w_wr_addr[AW-1]) begin
            if (k < 2) mem[w_wr_addr[6:1]][k*32 +: 32] <= w_wr_data[k*32 +: 32];
          end else csr[w_wr_addr[6:2]][k*32 +: 32] <= w_wr_data[k*32 +: 32];
        end
    end
    if (rst_n && w_rd_en) begin
      n_latch <= n_latch + 1;
      if (!w_rd_addr[AW-1] && w_rd_addr[6:2] == 5'd3) csr[3] <= '0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hrd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); h_addr = a; h_rd = 1'b1;
    @(negedge clk); h_rd = 1'b0; d = h_rdata;
    chk(h_rvalid, "R2 rvalid", {127'b0, h_rvalid}, 128'd1);
  endtask

  task automatic t_reset;
    chk(!h_rvalid && !w_wr_en && !w_rd_en, "R2 reset idle",
        {h_rvalid, w_wr_en, w_rd_en}, 128'd0);
  endtask

  task automatic t_csr_write;
    int c0;
    c0 = n_commit;
    csr[2] = '0;
    hwr(8'd8, 32'h1111_0000); hwr(8'd9, 32'h2222_0001); hwr(8'd10, 32'h3333_0002);
    chk(n_commit == c0 && csr[2] == 0, "R5 no early commit", csr[2], 128'd0);
    hwr(8'd11, 32'h4444_0003);
    chk(n_commit == c0 + 1, "R5 single commit", n_commit - c0, 128'd1);
    chk(csr[2] == 128'h4444_0003_3333_0002_2222_0001_1111_0000, "R5 R1 committed value",
        csr[2], 128'h4444_0003_3333_0002_2222_0001_1111_0000);
  endtask

  task automatic t_snapshot;
    logic [31:0] d;
    int l0;
    l0 = n_latch;
    hrd(8'd8, d);
    chk(d == 32'h1111_0000 && n_latch == l0 + 1, "R2 lane0 latch", d, 32'h1111_0000);
    csr[2] = {4{32'hDEAD_BEEF}};
    hrd(8'd9, d);
    chk(d == 32'h2222_0001, "R4 lane1 from snapshot", d, 32'h2222_0001);
    hrd(8'd11, d);
    chk(d == 32'h4444_0003 && n_latch == l0 + 1, "R4 lane3 from snapshot", d, 32'h4444_0003);
    hrd(8'd8, d);
    chk(d == 32'hDEAD_BEEF, "R2 lane0 relatch", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_other_reg;
    logic [31:0] d;
    csr[4] = 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0;
    hrd(8'd18, d);
    chk(d == 32'hA2A2A2A2, "R3 other register latches", d, 32'hA2A2A2A2);
  endtask

  task automatic t_mem;
    logic [31:0] d;
    int c0;
    c0 = n_commit;
    mem[5] = '0;
    hwr(8'd139, 32'hBBBB_0001);
    chk(n_commit == c0, "R6 mem no early commit", n_commit - c0, 128'd0);
    hwr(8'd138, 32'hAAAA_0000);
    chk(mem[5] == 64'hBBBB_0001_AAAA_0000 && n_commit == c0 + 1, "R6 mem commit",
        mem[5], 64'hBBBB_0001_AAAA_0000);
    hrd(8'd138, d);
    mem[5] = '0;
    hrd(8'd139, d);
    chk(d == 32'hBBBB_0001, "R6 mem snapshot", d, 32'hBBBB_0001);
  endtask

  task automatic t_order;
    csr[9] = '0;
    hwr(8'd39, 32'h33); hwr(8'd37, 32'h11); hwr(8'd36, 32'h00);
    chk(csr[9] == 0, "R7 waits for set", csr[9], 128'd0);
    hwr(8'd38, 32'h22);
    chk(csr[9] == {32'h33, 32'h22, 32'h11, 32'h00}, "R7 any order",
        csr[9], {32'h33, 32'h22, 32'h11, 32'h00});
  endtask

  task automatic t_drop;
    csr[5] = 128'h5; csr[6] = '0;
    hwr(8'd20, 32'hF0); hwr(8'd21, 32'hF1);
    hwr(8'd24, 32'h60); hwr(8'd25, 32'h61); hwr(8'd26, 32'h62); hwr(8'd27, 32'h63);
    chk(csr[6] == {32'h63, 32'h62, 32'h61, 32'h60}, "R8 new target commits",
        csr[6], {32'h63, 32'h62, 32'h61, 32'h60});
    hwr(8'd22, 32'hF2); hwr(8'd23, 32'hF3);
    chk(csr[5] == 128'h5, "R8 pending dropped", csr[5], 128'h5);
  endtask

  task automatic t_fresh;
    int c0;
    c0 = n_commit;
    hwr(8'd8, 32'h9); hwr(8'd9, 32'h9); hwr(8'd10, 32'h9);
    chk(n_commit == c0, "R9 mask cleared after commit", n_commit - c0, 128'd0);
    hwr(8'd11, 32'h9);
    chk(csr[2] == {4{32'h9}}, "R9 commit after full set", csr[2], {4{32'h9}});
  endtask

  task automatic t_rtc;
    logic [31:0] d;
    int l0;
    csr[3] = 128'h4_0000_0003_0000_0002_0000_0001;
    l0 = n_latch;
    hrd(8'd12, d);
    chk(csr[3] == 0 && d == 32'h1, "R10 clear on latch", csr[3], 128'd0);
    hrd(8'd13, d);
    chk(d == 32'h2, "R10 snapshot keeps value", d, 32'h2);
    hrd(8'd14, d); hrd(8'd15, d);
    chk(d == 32'h4 && n_latch == l0 + 1, "R10 one latch pulse", n_latch - l0, 128'd1);
  endtask

  task automatic t_bypass;
    int c0;
    csr[7] = {4{32'h7777_7777}};
    c0 = n_commit;
    hwr(8'd30, 32'h0000_ABCD);
    chk(n_commit == c0 + 1, "R11 immediate commit", n_commit - c0, 128'd1);
    chk(csr[7] == {32'h7777_7777, 32'h0000_ABCD, 32'h7777_7777, 32'h7777_7777},
        "R11 single lane", csr[7], {32'h7777_7777, 32'h0000_ABCD, 32'h7777_7777, 32'h7777_7777});
  endtask

  initial begin
    for (int i = 0; i < 32; i++) csr[i] = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_csr_write();
    t_snapshot();
    t_other_reg();
    t_mem();
    t_order();
    t_drop();
    t_fresh();
    t_rtc();
    t_bypass();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule